// File: doc/BRIEF.md
# Dual-Channel Output Formatter and Multiplexer

This block sits between a two-channel sample source and the output pins. Each sampling instant delivers one offset-binary word per channel plus an over-range flag per channel. The block recodes each word into the selected output code, optionally mirrors its bit order, and drives the result either as two parallel buses or interleaved on a single bus. In interleaved mode a channel indicator marks which channel the bus carries.

The block runs on a clock at twice the sample rate, so one clock cycle is one half sample period. A new sample pair is offered with a one-cycle `in_valid` pulse no more often than every second cycle. The configuration inputs are sampled together with the data on that pulse. Each emitted word is marked by `out_valid`. In dual-bus mode the block can hold the output back by one extra half period.

Top module: `dual_out_fmt`

## Requirements
- R1: After reset, both data buses, both flag outputs, `out_chan` and `out_valid` are 0.
- R2: `cfg_code` selects the output code of each word: 0 passes offset binary unchanged, 1 gives two's complement (most significant bit inverted), 2 gives Gray code (b XOR (b >> 1)), and 3 behaves as 0.
- R3: With `cfg_rev` = 1, the coded word is mirrored after coding, so coded bit i appears on output bit W-1-i.
- R4: In dual-bus mode (`cfg_mux` = 0, `cfg_half_dly` = 0), channel A drives `out_a` with `out_or_a`, and channel B drives `out_b` with `out_or_b`. A single `out_valid` pulse marks them in the second cycle after the capturing edge. The buses then hold their values until the next word.
- R5: In multiplexed mode (`cfg_mux` = 1), the channel A word appears in the second cycle after capture with `out_chan` = 0. The channel B word of the same instant follows in the very next cycle with `out_chan` = 1. Both cycles carry `out_valid`, and each word's flag comes out on the flag output of the carrying bus.
- R6: In multiplexed mode, `cfg_mux_bus` = 0 puts the stream on `out_a` and `out_or_a`, and `cfg_mux_bus` = 1 puts it on `out_b` and `out_or_b`. The other bus and its flag are 0 while the stream is emitted.
- R7: In dual-bus mode with `cfg_half_dly` = 1, the output and its strobe come one cycle later than in R4.
- R8: `cfg_half_dly` has no effect in multiplexed mode: the timing of R5 holds for either value.
- R9: Configuration and data are taken only on the `in_valid` cycle. Changes to them in later cycles do not alter words already captured.
- R10: With `in_valid` every second cycle, every sample pair is emitted in order with no loss, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New sample pair present |
| in_a | input | W | Channel A sample, offset binary |
| in_b | input | W | Channel B sample, offset binary |
| in_or_a | input | 1 | Channel A over-range |
| in_or_b | input | 1 | Channel B over-range |
| cfg_code | input | 2 | Output code select (R2) |
| cfg_rev | input | 1 | Bit-order mirror enable |
| cfg_mux | input | 1 | 1 = interleave on one bus |
| cfg_mux_bus | input | 1 | Bus carrying the interleaved stream |
| cfg_half_dly | input | 1 | Extra half-period delay in dual-bus mode |
| out_a | output | W | Output bus A |
| out_b | output | W | Output bus B |
| out_or_a | output | 1 | Over-range flag on bus A |
| out_or_b | output | 1 | Over-range flag on bus B |
| out_chan | output | 1 | 1 while bus carries channel B in interleaved mode |
| out_valid | output | 1 | Output word strobe |

## Verification
The assertions assume that `in_valid` never rises in two consecutive cycles. A pulse arriving while a multiplexed pair is half emitted would otherwise cut its second word. The stimulus task always leaves at least one idle cycle after each pulse, and the back-to-back runs use exactly that minimum spacing. The latency properties also assume the configuration pins are steady in the pulse cycle. The driver therefore sets them together with the data in the same half cycle and changes them only afterwards.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    typedef enum logic [1:0] {
        CODE_OFFSET = 2'd0,
        CODE_TWOS   = 2'd1,
        CODE_GRAY   = 2'd2,
        CODE_ALT    = 2'd3
    } out_code_e;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_A    = 2'd1,
        STEP_B    = 2'd2
    } step_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/fmt_code.sv
module fmt_code
    import fmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic [1:0]   code,
    input  logic         rev,
    output logic [W-1:0] word
);
    logic [W-1:0] coded;
    logic [W-1:0] mirrored;

    always_comb begin
        case (out_code_e'(code))
            CODE_TWOS: coded = raw ^ {1'b1, {(W-1){1'b0}}};
            CODE_GRAY: coded = raw ^ (raw >> 1);
            default:   coded = raw;
        endcase
    end

    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign mirrored[i] = coded[W-1-i];
    end

    assign word = rev ? mirrored : coded;
endmodule

// File: rtl/fmt_out_sel.sv
module fmt_out_sel #(
    parameter int W = 8
) (
    input  logic         mux,
    input  logic         bus_sel,
    input  logic         second,
    input  logic [W-1:0] word_a,
    input  logic [W-1:0] word_b,
    input  logic         flag_a,
    input  logic         flag_b,
    output logic [W-1:0] bus_a,
    output logic [W-1:0] bus_b,
    output logic         fl_a,
    output logic         fl_b
);
    logic [W-1:0] stream_w;
    logic         stream_f;

    assign stream_w = second ? word_b : word_a;
    assign stream_f = second ? flag_b : flag_a;

    always_comb begin
        if (!mux) begin
            bus_a = word_a;
            bus_b = word_b;
            fl_a  = flag_a;
            fl_b  = flag_b;
        end else if (!bus_sel) begin
            bus_a = stream_w;
            bus_b = '0;
            fl_a  = stream_f;
            fl_b  = 1'b0;
        end else begin
            bus_a = '0;
            bus_b = stream_w;
            fl_a  = 1'b0;
            fl_b  = stream_f;
        end
    end
endmodule

// File: rtl/dual_out_fmt.sv
module dual_out_fmt
    import fmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         in_or_a,
    input  logic         in_or_b,
    input  logic [1:0]   cfg_code,
    input  logic         cfg_rev,
    input  logic         cfg_mux,
    input  logic         cfg_mux_bus,
    input  logic         cfg_half_dly,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b,
    output logic         out_or_a,
    output logic         out_or_b,
    output logic         out_chan,
    output logic         out_valid
);
    typedef struct packed {
        logic [W-1:0] wa;
        logic [W-1:0] wb;
        logic         ha;
        logic         hb;
        logic         mux;
        logic         bus;
        logic         dly;
        step_e        step;
        logic [W-1:0] oa;
        logic [W-1:0] ob;
        logic         foa;
        logic         fob;
        logic         chan;
        logic         vld;
        logic         omux;
        logic         obus;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0] raw_w  [NUM_CH];
    logic [W-1:0] code_w [NUM_CH];

    assign raw_w[0] = in_a;
    assign raw_w[1] = in_b;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fmt_code #(.W(W)) u_code (
            .raw  (raw_w[c]),
            .code (cfg_code),
            .rev  (cfg_rev),
            .word (code_w[c])
        );
    end

    logic [W-1:0] sel_a, sel_b;
    logic         sel_fa, sel_fb;

    fmt_out_sel #(.W(W)) u_sel (
        .mux     (st_q.mux),
        .bus_sel (st_q.bus),
        .second  (st_q.step == STEP_B),
        .word_a  (st_q.wa),
        .word_b  (st_q.wb),
        .flag_a  (st_q.ha),
        .flag_b  (st_q.hb),
        .bus_a   (sel_a),
        .bus_b   (sel_b),
        .fl_a    (sel_fa),
        .fl_b    (sel_fb)
    );

    logic emit;
    assign emit = ((st_q.step == STEP_A) && (st_q.mux || !st_q.dly)) ||
                  ((st_q.step == STEP_B) && (st_q.mux ||  st_q.dly));

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.chan = 1'b0;
        if (emit) begin
            st_d.oa   = sel_a;
            st_d.ob   = sel_b;
            st_d.foa  = sel_fa;
            st_d.fob  = sel_fb;
            st_d.chan = st_q.mux && (st_q.step == STEP_B);
            st_d.vld  = 1'b1;
            st_d.omux = st_q.mux;
            st_d.obus = st_q.bus;
        end
        case (st_q.step)
            STEP_A:  st_d.step = STEP_B;
            default: st_d.step = STEP_IDLE;
        endcase
        if (in_valid) begin
            st_d.wa   = code_w[0];
            st_d.wb   = code_w[1];
            st_d.ha   = in_or_a;
            st_d.hb   = in_or_b;
            st_d.mux  = cfg_mux;
            st_d.bus  = cfg_mux_bus;
            st_d.dly  = cfg_half_dly;
            st_d.step = STEP_A;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_a     = st_q.oa;
    assign out_b     = st_q.ob;
    assign out_or_a  = st_q.foa;
    assign out_or_b  = st_q.fob;
    assign out_chan  = st_q.chan;
    assign out_valid = st_q.vld;

    // input rule behind R10: pulses are at least two cycles apart
    assert_in_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !in_valid);

    assert_dual_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_mux && !cfg_half_dly) |=> ##1 out_valid);

    assert_dual_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_mux && cfg_half_dly) |=> ##1 !out_valid ##1 out_valid);

    // R8: the mux timing is the same whatever cfg_half_dly says
    assert_mux_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_mux) |=> ##1 (out_valid && !out_chan) ##1 (out_valid && out_chan));

    assert_chan_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_chan |-> (out_valid && $past(out_valid)));

    assert_chan_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_chan |=> !out_chan);

    assert_idle_bus_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.omux && !st_q.obus) |-> (out_b == '0 && !out_or_b));

    assert_idle_bus_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.omux && st_q.obus) |-> (out_a == '0 && !out_or_a));
endmodule

// File: tb/dual_out_fmt_tb.sv
module dual_out_fmt_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0;
    logic in_or_a = 1'b0, in_or_b = 1'b0;
    logic [1:0] cfg_code = 2'd0;
    logic cfg_rev = 1'b0, cfg_mux = 1'b0, cfg_mux_bus = 1'b0, cfg_half_dly = 1'b0;
    logic [W-1:0] out_a, out_b;
    logic out_or_a, out_or_b, out_chan, out_valid;

    always #4 clk = ~clk;

    dual_out_fmt #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_or_a(in_or_a), .in_or_b(in_or_b),
        .cfg_code(cfg_code), .cfg_rev(cfg_rev), .cfg_mux(cfg_mux),
        .cfg_mux_bus(cfg_mux_bus), .cfg_half_dly(cfg_half_dly),
        .out_a(out_a), .out_b(out_b), .out_or_a(out_or_a), .out_or_b(out_or_b),
        .out_chan(out_chan), .out_valid(out_valid)
    );

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic fa;
        logic fb;
        logic ch;
        int   due;
        string req;
    } item_t;

    item_t exp_q[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [1:0] code,
                                           input logic rev);
        logic [W-1:0] c, r;
        case (code)
            2'd1:    c = x ^ 8'h80;
            2'd2:    c = x ^ (x >> 1);
            default: c = x;
        endcase
        for (int i = 0; i < W; i++) r[i] = c[W-1-i];
        return rev ? r : c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input string act, input string expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%s expected=%s", req, what, act, expv);
        end
    endtask

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic fa,
                        input logic fb, input logic [1:0] code, input logic rev,
                        input logic mux, input logic bsel, input logic dly,
                        input int gap, input bit scramble, input string req);
        item_t it;
        logic [W-1:0] wa, wb;
        int base;
        @(negedge clk);
        in_a = a; in_b = b; in_or_a = fa; in_or_b = fb;
        cfg_code = code; cfg_rev = rev; cfg_mux = mux; cfg_mux_bus = bsel;
        cfg_half_dly = dly; in_valid = 1'b1;
        base = cyc;
        wa = model(a, code, rev);
        wb = model(b, code, rev);
        it.req = req;
        if (!mux) begin
            it.a = wa; it.b = wb; it.fa = fa; it.fb = fb; it.ch = 1'b0;
            it.due = base + 2 + (dly ? 1 : 0);
            exp_q.push_back(it);
        end else begin
            it.ch = 1'b0; it.due = base + 2;
            it.a = bsel ? '0 : wa; it.b = bsel ? wa : '0;
            it.fa = bsel ? 1'b0 : fa; it.fb = bsel ? fa : 1'b0;
            exp_q.push_back(it);
            it.ch = 1'b1; it.due = base + 3;
            it.a = bsel ? '0 : wb; it.b = bsel ? wb : '0;
            it.fa = bsel ? 1'b0 : fb; it.fb = bsel ? fb : 1'b0;
            exp_q.push_back(it);
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin
            in_a = ~a; in_b = ~b; in_or_a = ~fa; in_or_b = ~fb;
            cfg_code = ~code; cfg_rev = ~rev; cfg_mux = ~mux;
            cfg_mux_bus = ~bsel; cfg_half_dly = ~dly;
        end
        for (int k = 0; k < gap - 2; k++) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (running && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected strobe", "valid", "idle");
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(cyc == e.due, e.req, "strobe cycle",
                      $sformatf("%0d", cyc), $sformatf("%0d", e.due));
                check({out_a, out_b, out_or_a, out_or_b, out_chan} ==
                      {e.a, e.b, e.fa, e.fb, e.ch}, e.req, "a/b/fa/fb/ch",
                      $sformatf("%h/%h/%b/%b/%b", out_a, out_b, out_or_a, out_or_b, out_chan),
                      $sformatf("%h/%h/%b/%b/%b", e.a, e.b, e.fa, e.fb, e.ch));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R10", "watchdog", "hung", "finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({out_a, out_b, out_or_a, out_or_b, out_chan, out_valid} == '0, "R1",
              "reset outputs", $sformatf("%h %h %b%b%b%b", out_a, out_b, out_or_a,
              out_or_b, out_chan, out_valid), "00 00 0000");
        running = 1'b1;

        // R2: each code, dual bus (R4)
        send(8'h3C, 8'hC5, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R2");
        send(8'h3C, 8'hC5, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R2");
        send(8'hB7, 8'h01, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R2");
        send(8'hB7, 8'hFF, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R2");
        // R3: mirror after coding
        send(8'h01, 8'h6A, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R3");
        send(8'hB7, 8'h80, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R3");
        send(8'h7F, 8'h12, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R4");
        // R7: half delay in dual mode
        send(8'h55, 8'hAA, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4, 1'b0, "R7");
        send(8'h9E, 8'h43, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b0, "R7");
        // R5/R6: interleaved on each bus
        send(8'h21, 8'hDE, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4, 1'b0, "R5");
        send(8'h21, 8'hDE, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4, 1'b0, "R6");
        send(8'hF0, 8'h0F, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4, 1'b0, "R6");
        // R8: delay ignored while interleaving
        send(8'h66, 8'h99, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4, 1'b0, "R8");
        send(8'hC3, 8'h3C, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 4, 1'b0, "R8");
        // R9: change inputs right after capture
        send(8'hA5, 8'h5A, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4, 1'b1, "R9");
        send(8'h18, 8'hE7, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 4, 1'b1, "R9");
        // R10: sustained every-other-cycle streams in each mode
        for (int n = 0; n < 6; n++)
            send(8'(n * 37 + 5), 8'(n * 91 + 2), n[0], n[1], 2'(n), n[2], 1'b0, 1'b0, 1'b0,
                 2, 1'b0, "R10");
        for (int n = 0; n < 6; n++)
            send(8'(n * 53 + 9), 8'(n * 29 + 7), n[1], n[0], 2'(n), n[0], 1'b1, n[1], 1'b0,
                 2, 1'b0, "R10");
        for (int n = 0; n < 6; n++)
            send(8'(n * 17 + 3), 8'(n * 71 + 1), n[0], n[0], 2'(n + 1), n[1], 1'b0, 1'b0,
                 1'b1, 2, 1'b0, "R10");

        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R10", "words left unemitted",
              $sformatf("%0d", exp_q.size()), "0");
        // R4: buses hold after the last dual word
        check(!out_valid && !out_chan, "R4", "idle strobe",
              $sformatf("%b%b", out_valid, out_chan), "00");
        finish_run();
    end
endmodule